// File: doc/BRIEF.md
# Flash Write-Protection Range Checker

This block sits between a flash command sequencer and the serial engine that drives the flash device. It decides, one cycle at a time, whether a requested flash cycle may start. Each request comes with a 24-bit flash address, two opcode-class bits and a start pulse. One clock later the block answers with a single-cycle grant or a single-cycle blocked indication. The blocked pulse is the status that the sequencer records in place of running the cycle.

Two kinds of policy apply. The first is a lower-bound fence. Any addressed cycle below the fence address is refused. The second is a set of three protected windows. Each window has an enable bit and a base and limit counted in 4 KiB pages. A write-class cycle that falls inside an enabled window is refused. Software programs the fence and the windows through a small write port. It can then set a lock. From then until reset, every change to those registers is ignored.

Top module: `flash_wp_guard`

## Requirements
- R1: After synchronous reset, `cfg_locked` is 0, the fence is 0, all three windows are disabled, and neither `cyc_grant` nor `cyc_blocked` is asserted, so any cycle is granted.
- R2: Every `cyc_start` pulse produces exactly one of `cyc_grant` or `cyc_blocked`, high for the single cycle after the start. In a cycle that follows no start, both are low.
- R3: An addressed cycle (`cyc_type[1]`=1) whose address is strictly below the fence is blocked, whatever its class. An address equal to the fence passes the fence.
- R4: A window register written with `cfg_sel` 1, 2 or 3 holds the enable in bit 31, the limit page in bits 23:12 and the base page in bits 11:0. It covers addresses from base×0x1000 through limit×0x1000+0xFFF, both ends included.
- R5: An addressed write-class cycle (`cyc_type[0]`=1) whose address lies inside any enabled window is blocked. The first address past either end of a window is granted.
- R6: Read-class cycles (`cyc_type[0]`=0) are never blocked by a window. Only the fence applies to them.
- R7: A window whose enable bit is 0 blocks nothing, even for write-class cycles inside its page span.
- R8: A cycle without an address (`cyc_type[1]`=0) is always granted.
- R9: A write to `cfg_sel` 4 with `cfg_wdata[0]`=1 sets `cfg_locked`. Writing 0 there has no effect. Once set, the lock stays set until reset.
- R10: While locked, writes to the fence (`cfg_sel` 0, bits 23:0) and to the window registers are ignored.
- R11: A configuration write takes effect for a cycle whose start pulse arrives on the clock right after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 fence, 1..3 windows, 4 lock |
| cfg_wdata | input | 32 | Configuration write data |
| cyc_start | input | 1 | Single-cycle request to start a flash cycle |
| cyc_addr | input | 24 | Flash address of the requested cycle |
| cyc_type | input | 2 | Bit 0 write-class, bit 1 carries an address |
| cyc_grant | output | 1 | Cycle may run (one cycle after start) |
| cyc_blocked | output | 1 | Cycle refused (one cycle after start) |
| cfg_locked | output | 1 | Configuration lock state |

## Verification
The bench probes both inclusive ends of each window and the first address beyond them. A design that compares full addresses and forgets that the limit page is filled with ones would let the top 4 KiB of a window through. The bench also probes the address one below the fence and the address equal to it, which catches an off-by-one comparison. Read-class and address-less cycles are sent into protected space to catch a design that applies windows to every cycle. Writes of 0 to the lock, and writes of new values after locking, expose a lock that toggles or a freeze that misses one register.

// File: rtl/wp_pkg.sv
package wp_pkg;

    localparam int ADDR_W     = 24;
    localparam int PAGE_SHIFT = 12;
    localparam int PG_W       = ADDR_W - PAGE_SHIFT;
    localparam int NUM_RANGES = 3;
    localparam int CFG_DW     = 32;
    localparam int SEL_W      = 3;
    localparam int EN_BIT     = 31;
    localparam int LIM_LSB    = 12;

    localparam int SEL_FENCE  = 0;
    localparam int SEL_RANGE0 = 1;
    localparam int SEL_LOCK   = SEL_RANGE0 + NUM_RANGES;

    // one protected window, page granular
    typedef struct packed {
        logic            en;
        logic [PG_W-1:0] limit;
        logic [PG_W-1:0] base;
    } wp_range_t;

    // request as seen by the decision stage
    typedef struct packed {
        logic              valid;
        logic              is_write;
        logic              has_addr;
        logic [ADDR_W-1:0] addr;
    } wp_req_t;

    typedef enum logic [1:0] {
        V_IDLE  = 2'd0,
        V_GRANT = 2'd1,
        V_BLOCK = 2'd2
    } wp_verdict_e;

    function automatic logic page_in_range(wp_range_t r, logic [PG_W-1:0] page);
        return r.en && (page >= r.base) && (page <= r.limit);
    endfunction

endpackage

// File: rtl/wp_cfg_regs.sv
module wp_cfg_regs
    import wp_pkg::*;
#(
    parameter int N_RANGES = NUM_RANGES
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic [SEL_W-1:0]              cfg_sel,
    input  logic [CFG_DW-1:0]             cfg_wdata,
    output logic [ADDR_W-1:0]             fence_o,
    output wp_range_t [N_RANGES-1:0]      ranges_o,
    output logic                          locked_o
);

    logic                     lock_q;
    logic [ADDR_W-1:0]        fence_q;
    wp_range_t [N_RANGES-1:0] ranges_q;
    logic                     unused_cfg_bits;

    assign unused_cfg_bits = ^cfg_wdata[EN_BIT-1:ADDR_W];

    // sticky lock, set only by a one in bit 0
    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
        end else if (cfg_we && cfg_sel == SEL_W'(SEL_LOCK) && cfg_wdata[0]) begin
            lock_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fence_q <= '0;
        end else if (cfg_we && !lock_q && cfg_sel == SEL_W'(SEL_FENCE)) begin
            fence_q <= cfg_wdata[ADDR_W-1:0];
        end
    end

    for (genvar g = 0; g < N_RANGES; g++) begin : g_range
        always_ff @(posedge clk) begin
            if (rst) begin
                ranges_q[g] <= '0;
            end else if (cfg_we && !lock_q && cfg_sel == SEL_W'(SEL_RANGE0 + g)) begin
                ranges_q[g].en    <= cfg_wdata[EN_BIT];
                ranges_q[g].limit <= cfg_wdata[LIM_LSB+PG_W-1:LIM_LSB];
                ranges_q[g].base  <= cfg_wdata[PG_W-1:0];
            end
        end
    end

    assign fence_o  = fence_q;
    assign ranges_o = ranges_q;
    assign locked_o = lock_q;

    // R9: lock never clears without reset
    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> lock_q);

    // R10: locked configuration is frozen
    a_r10_fence_frozen: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> $stable(fence_q));

    a_r10_ranges_frozen: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> $stable(ranges_q));

endmodule

// File: rtl/wp_range_cmp.sv
module wp_range_cmp
    import wp_pkg::*;
#(
    parameter int N_RANGES = NUM_RANGES
) (
    input  wp_range_t [N_RANGES-1:0] ranges_i,
    input  logic [PG_W-1:0]          page_i,
    output logic [N_RANGES-1:0]      hit_o
);

    // one comparator pair per window; low 12 address bits never matter
    for (genvar g = 0; g < N_RANGES; g++) begin : g_cmp
        assign hit_o[g] = page_in_range(ranges_i[g], page_i);
    end

endmodule

// File: rtl/wp_decide.sv
module wp_decide
    import wp_pkg::*;
#(
    parameter int N_RANGES = NUM_RANGES
) (
    input  logic                clk,
    input  logic                rst,
    input  wp_req_t             req_i,
    input  logic [ADDR_W-1:0]   fence_i,
    input  logic [N_RANGES-1:0] hit_i,
    output logic                grant_o,
    output logic                blocked_o
);

    wp_verdict_e verdict_d, verdict_q;
    logic        below_fence;
    logic        wp_hit;

    assign below_fence = req_i.has_addr && (req_i.addr < fence_i);
    assign wp_hit      = req_i.has_addr && req_i.is_write && (|hit_i);

    always_comb begin
        verdict_d = V_IDLE;
        if (req_i.valid) begin
            verdict_d = (below_fence || wp_hit) ? V_BLOCK : V_GRANT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q <= V_IDLE;
        end else begin
            verdict_q <= verdict_d;
        end
    end

    assign grant_o   = (verdict_q == V_GRANT);
    assign blocked_o = (verdict_q == V_BLOCK);

    // R2: one answer per start, none otherwise
    a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(grant_o && blocked_o));

    a_r2_answer: assert property (@(posedge clk) disable iff (rst)
        req_i.valid |=> (grant_o || blocked_o));

    a_r2_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_i.valid |=> (!grant_o && !blocked_o));

    // R3: addressed cycle under the fence is refused
    a_r3_fence: assert property (@(posedge clk) disable iff (rst)
        (req_i.valid && req_i.has_addr && req_i.addr < fence_i) |=> blocked_o);

    // R6: reads at or above the fence always pass
    a_r6_read_passes: assert property (@(posedge clk) disable iff (rst)
        (req_i.valid && !req_i.is_write && req_i.has_addr && req_i.addr >= fence_i)
        |=> grant_o);

    // R8: cycles without an address always pass
    a_r8_no_addr: assert property (@(posedge clk) disable iff (rst)
        (req_i.valid && !req_i.has_addr) |=> grant_o);

endmodule

// File: rtl/flash_wp_guard.sv
module flash_wp_guard
    import wp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              cyc_start,
    input  logic [23:0]       cyc_addr,
    input  logic [1:0]        cyc_type,
    output logic              cyc_grant,
    output logic              cyc_blocked,
    output logic              cfg_locked
);

    logic [ADDR_W-1:0]          fence;
    wp_range_t [NUM_RANGES-1:0] ranges;
    logic [NUM_RANGES-1:0]      hits;
    wp_req_t                    req;

    assign req.valid    = cyc_start;
    assign req.is_write = cyc_type[0];
    assign req.has_addr = cyc_type[1];
    assign req.addr     = cyc_addr;

    wp_cfg_regs #(.N_RANGES(NUM_RANGES)) cfg_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .fence_o   (fence),
        .ranges_o  (ranges),
        .locked_o  (cfg_locked)
    );

    wp_range_cmp #(.N_RANGES(NUM_RANGES)) cmp_i (
        .ranges_i (ranges),
        .page_i   (cyc_addr[ADDR_W-1:PAGE_SHIFT]),
        .hit_o    (hits)
    );

    wp_decide #(.N_RANGES(NUM_RANGES)) dec_i (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req),
        .fence_i   (fence),
        .hit_i     (hits),
        .grant_o   (cyc_grant),
        .blocked_o (cyc_blocked)
    );

    // R5: write into an enabled window is refused (window 0 checked from stored fields)
    a_r5_window_blocks: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && cyc_type == 2'b11 &&
         page_in_range(ranges[0], cyc_addr[ADDR_W-1:PAGE_SHIFT])) |=> cyc_blocked);

endmodule

// File: tb/flash_wp_guard_tb_top.sv
module flash_wp_guard_tb_top;

    localparam logic [1:0] T_NOADDR = 2'b00;
    localparam logic [1:0] T_READ   = 2'b10;
    localparam logic [1:0] T_WRITE  = 2'b11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cyc_start = 1'b0;
    logic [23:0] cyc_addr = '0;
    logic [1:0]  cyc_type = '0;
    logic        cyc_grant;
    logic        cyc_blocked;
    logic        cfg_locked;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    flash_wp_guard dut_i (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .cyc_start   (cyc_start),
        .cyc_addr    (cyc_addr),
        .cyc_type    (cyc_type),
        .cyc_grant   (cyc_grant),
        .cyc_blocked (cyc_blocked),
        .cfg_locked  (cfg_locked)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] win(input bit en, input logic [11:0] lim,
                                        input logic [11:0] base);
        return {en, 7'b0, lim, base};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // start one cycle, check verdict one clock later, then check the idle cycle
    task automatic run_cycle(input logic [23:0] addr, input logic [1:0] ty,
                             input bit exp_block, input string req);
        @(negedge clk);
        cyc_start = 1'b1; cyc_addr = addr; cyc_type = ty;
        @(negedge clk);
        cyc_start = 1'b0;
        check(cyc_blocked == exp_block && cyc_grant == !exp_block, req,
              {30'b0, cyc_grant, cyc_blocked}, {30'b0, !exp_block, exp_block});
        @(negedge clk);
        check(!cyc_grant && !cyc_blocked, "R2 idle after verdict",
              {30'b0, cyc_grant, cyc_blocked}, 32'h0);
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        check(cfg_locked == 1'b0, "R1 lock clear", {31'b0, cfg_locked}, 32'h0);
        check(!cyc_grant && !cyc_blocked, "R1 outputs idle",
              {30'b0, cyc_grant, cyc_blocked}, 32'h0);
        run_cycle(24'h000000, T_WRITE, 1'b0, "R1 write at 0 granted");
        run_cycle(24'hFFFFFF, T_WRITE, 1'b0, "R1 write at top granted");
    endtask

    task automatic t_fence();
        cfg_write(3'd0, 32'h0010_0000);
        run_cycle(24'h0FFFFF, T_READ,   1'b1, "R3 R11 read below fence");
        run_cycle(24'h0FFFFF, T_WRITE,  1'b1, "R3 write below fence");
        run_cycle(24'h100000, T_READ,   1'b0, "R3 read at fence");
        run_cycle(24'h000000, T_NOADDR, 1'b0, "R8 no-address cycle");
    endtask

    task automatic t_windows();
        cfg_write(3'd1, win(1'b1, 12'h203, 12'h200));
        run_cycle(24'h200000, T_WRITE, 1'b1, "R4 R5 window base");
        run_cycle(24'h203FFF, T_WRITE, 1'b1, "R4 R5 window last byte");
        run_cycle(24'h1FFFFF, T_WRITE, 1'b0, "R5 below window");
        run_cycle(24'h204000, T_WRITE, 1'b0, "R5 past window");
        run_cycle(24'h201000, T_READ,  1'b0, "R6 read in window");
        run_cycle(24'h201000, T_NOADDR | 2'b01, 1'b0, "R8 write no address");
        cfg_write(3'd2, win(1'b0, 12'h300, 12'h300));
        run_cycle(24'h300800, T_WRITE, 1'b0, "R7 disabled window");
        cfg_write(3'd3, win(1'b1, 12'h400, 12'h400));
        run_cycle(24'h400FFF, T_WRITE, 1'b1, "R5 single-page window");
        run_cycle(24'h401000, T_WRITE, 1'b0, "R5 after single page");
    endtask

    task automatic t_lock();
        cfg_write(3'd4, 32'h0000_0000);
        @(negedge clk);
        check(cfg_locked == 1'b0, "R9 zero write no lock", {31'b0, cfg_locked}, 32'h0);
        cfg_write(3'd4, 32'h0000_0001);
        @(negedge clk);
        check(cfg_locked == 1'b1, "R9 lock set", {31'b0, cfg_locked}, 32'h1);
        cfg_write(3'd0, 32'h0000_0000);
        run_cycle(24'h0FFFFF, T_READ, 1'b1, "R10 fence frozen");
        cfg_write(3'd1, win(1'b0, 12'h000, 12'h000));
        run_cycle(24'h200000, T_WRITE, 1'b1, "R10 window frozen");
        cfg_write(3'd2, win(1'b1, 12'h300, 12'h300));
        run_cycle(24'h300800, T_WRITE, 1'b0, "R10 window stays disabled");
        cfg_write(3'd4, 32'h0000_0000);
        @(negedge clk);
        check(cfg_locked == 1'b1, "R9 lock sticky", {31'b0, cfg_locked}, 32'h1);
    endtask

    task automatic t_reset_clears();
        do_reset();
        @(negedge clk);
        check(cfg_locked == 1'b0, "R1 R9 reset clears lock", {31'b0, cfg_locked}, 32'h0);
        run_cycle(24'h0FFFFF, T_READ,  1'b0, "R1 fence cleared");
        run_cycle(24'h200000, T_WRITE, 1'b0, "R1 windows cleared");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_fence();
        t_windows();
        t_lock();
        t_reset_clears();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule